// File: doc/BRIEF.md
# Full-Duplex Serial Port with a Shared Data Address

This block is a memory-mapped asynchronous serial port for a simple CPU bus. A single data address leads to two unrelated registers. A bus write there feeds the transmit queue. A bus read there takes the oldest byte from the receive queue. Because the two registers are separate, a read never returns what software last wrote. The transmit and receive lines are independent, so both directions can carry frames at the same time.

Each direction keeps a 16-entry FIFO in front of its own shift register. A transmit byte can therefore be shifted out while software queues more bytes, and an incoming byte can be assembled while earlier bytes wait to be collected. A status register reports receive-available, transmit-room and two sticky error flags. A programmable divider sets the 16x oversampling rate. Two interrupt outputs, each with its own enable, follow the two availability flags.

Top module: `uart_duplex_port`

## Requirements
- R1: Address 0 is the data address. A bus write there enqueues into the transmit FIFO. A bus read there returns the head of the receive FIFO and never the last written value.
- R2: The serial frame is one low start bit, 8 data bits LSB first, and one high stop bit. The line idles high. Each bit lasts 16*(DIV+1) clock cycles, where DIV is the divider value.
- R3: Transmit and receive run at the same time on separate lines without disturbing each other.
- R4: Each FIFO holds 16 bytes. The transmit shift register is separate from its FIFO, so 17 back-to-back writes are all accepted and all transmitted in order.
- R5: A data write while the transmit FIFO is full is dropped and sets the sticky overflow flag (status bit 2).
- R6: A frame that completes while the receive FIFO is full is discarded and sets the sticky overrun flag (status bit 3).
- R7: A data read pops the receive FIFO in the same cycle it presents the byte. A data read of an empty FIFO returns 0 and changes no state.
- R8: The status register at address 1 reads bit 0 = receive data available (FIFO not empty) and bit 1 = transmit room (FIFO not full). Any write to address 1 clears bits 2 and 3. If a flag is set and cleared in the same cycle, the set wins.
- R9: The receiver confirms a start bit only if the line is still low at mid-bit. A shorter low pulse is ignored. A frame whose stop bit is low is discarded, and the receiver waits for the line to return high.
- R10: The divider register at address 2 is readable and writable. Its reset value is 3.
- R11: The control register at address 3 has bit 0 = receive interrupt enable and bit 1 = transmit interrupt enable. The receive interrupt equals bit 0 AND receive-available. The transmit interrupt equals bit 1 AND transmit-room.
- R12: After reset both FIFOs are empty, the flags are clear, interrupts are disabled, the transmit line is high, and the status register reads 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during the access cycle |
| serial_tx | output | 1 | Transmit line |
| serial_rx | input | 1 | Receive line (asynchronous) |
| irq_rx | output | 1 | Receive-available interrupt |
| irq_tx | output | 1 | Transmit-room interrupt |

## Verification
Register reads are combinational, so the bench drives an access on a falling edge and samples the result a few nanoseconds later. Write and pop effects appear after the next rising edge and are read back in a later access. Serial results arrive a whole frame later (160*(DIV+1) cycles plus synchronizer delay). The bench decodes the transmit line at its own mid-bit points, counted from the falling start edge. It reads the receive FIFO only after waiting for the last frame plus a margin of at least one bit. Flag checks are placed after the complete burst that should set or clear them.

// File: rtl/uart_dx_pkg.sv
// Package: shared constants and state encodings for the duplex serial port.
// Assumes an 8N1 frame with a fixed 16x oversampling ratio.
package uart_dx_pkg;
    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;
    localparam logic [1:0] ADDR_CTRL = 2'd3;
    localparam int OVERSAMPLE = 16;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HI} rx_state_e;
endpackage

// File: rtl/dx_fifo.sv
// dx_fifo: synchronous first-in first-out queue with a head output that can be read
// without popping. A push when full and a pop when empty are ignored.
// Assumes DEPTH is a power of two so that the pointers wrap naturally.
module dx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];
    assign count   = cnt;

    // Store accepted data at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/dx_baud.sv
// dx_baud: free-running divider that gives a one-cycle oversampling tick every
// DIV+1 clock cycles. If the divisor is lowered below the running count, the
// counter wraps on the next cycle.
module dx_baud #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;

    assign tick = (cnt >= div);

    // Count up to the divisor, then restart.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dx_tx.sv
// dx_tx: transmit shifter. Takes a byte from its FIFO when idle and sends start,
// 8 data bits LSB first and stop, each OVERSAMPLE ticks long. The shift register
// is separate from the FIFO, so the FIFO can refill while a frame is on the line.
module dx_tx
    import uart_dx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int TW = $clog2(OVERSAMPLE),
    localparam int BW = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_dout,
    output logic              fifo_pop,
    output logic              tx,
    output logic              busy
);
    tx_state_e         state;
    logic [TW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] sh;
    logic              bit_end;

    assign fifo_pop = (state == TX_IDLE) && !fifo_empty;
    assign busy     = (state != TX_IDLE);
    assign bit_end  = tick && (tcnt == TW'(OVERSAMPLE - 1));

    // Frame sequencer: load, then time each bit and move the next bit onto the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            tcnt  <= '0;
            bidx  <= '0;
            sh    <= '0;
            tx    <= 1'b1;
        end else begin
            if (tick && state != TX_IDLE) tcnt <= tcnt + 1'b1;
            case (state)
                TX_IDLE: begin
                    tx <= 1'b1;
                    if (!fifo_empty) begin
                        sh    <= fifo_dout;
                        tcnt  <= '0;
                        tx    <= 1'b0;
                        state <= TX_START;
                    end
                end
                TX_START: if (bit_end) begin
                    tx    <= sh[0];
                    sh    <= sh >> 1;
                    bidx  <= '0;
                    state <= TX_DATA;
                end
                TX_DATA: if (bit_end) begin
                    if (bidx == BW'(DATA_W - 1)) begin
                        tx    <= 1'b1;
                        state <= TX_STOP;
                    end else begin
                        tx   <= sh[0];
                        sh   <= sh >> 1;
                        bidx <= bidx + 1'b1;
                    end
                end
                TX_STOP: if (bit_end) state <= TX_IDLE;
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dx_rx.sv
// dx_rx: receive shifter. Synchronises the line, confirms a start bit at mid-bit,
// samples each data bit at its centre and checks the stop bit. It pulses
// frame_ok for one cycle with the assembled byte. After a low stop bit it waits
// for the line to go high before looking for a new start. The line is asynchronous.
module dx_rx
    import uart_dx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int TW = $clog2(OVERSAMPLE),
    localparam int BW = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    output logic              frame_ok,
    output logic [DATA_W-1:0] data
);
    rx_state_e     state;
    logic [1:0]    sync;
    logic          rxs;
    logic [TW-1:0] tcnt;
    logic [BW-1:0] bidx;
    logic          full_bit, half_bit;

    assign rxs      = sync[1];
    assign full_bit = tick && (tcnt == TW'(OVERSAMPLE - 1));
    assign half_bit = tick && (tcnt == TW'(OVERSAMPLE / 2 - 1));

    // Two-stage synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rx};
    end

    // Frame receiver state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            data     <= '0;
            frame_ok <= 1'b0;
        end else begin
            frame_ok <= 1'b0;
            if (tick) tcnt <= tcnt + 1'b1;
            case (state)
                RX_IDLE: if (!rxs) begin
                    tcnt  <= '0;
                    state <= RX_START;
                end
                RX_START: if (half_bit) begin
                    tcnt  <= '0;
                    bidx  <= '0;
                    state <= rxs ? RX_IDLE : RX_DATA;
                end
                RX_DATA: if (full_bit) begin
                    data <= {rxs, data[DATA_W-1:1]};
                    if (bidx == BW'(DATA_W - 1)) state <= RX_STOP;
                    else                         bidx  <= bidx + 1'b1;
                end
                RX_STOP: if (full_bit) begin
                    frame_ok <= rxs;
                    state    <= rxs ? RX_IDLE : RX_WAIT_HI;
                end
                RX_WAIT_HI: if (rxs) state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_duplex_port.sv
// uart_duplex_port: bus-mapped full-duplex serial port. The data address is two
// registers: writes feed the transmit FIFO and reads pop the receive FIFO.
// Also provides status with sticky error flags, a divider and interrupt enables.
// Assumes single-cycle bus accesses and a combinational read path.
module uart_duplex_port
    import uart_dx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 8,
    parameter int DIV_RESET  = 3,
    localparam int CW = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              serial_tx,
    input  logic              serial_rx,
    output logic              irq_rx,
    output logic              irq_tx
);
    logic [DIV_W-1:0]  div_q;
    logic              en_rx, en_tx, ovf_q, ovr_q;
    logic              tick;
    logic              wr_data, rd_data, wr_stat;
    logic              tx_push, tx_pop, tx_empty, tx_full, tx_busy;
    logic [DATA_W-1:0] tx_head;
    logic [CW-1:0]     tx_count;
    logic              rx_push, rx_pop, rx_empty, rx_full, rx_done;
    logic [DATA_W-1:0] rx_head, rx_byte;
    logic [CW-1:0]     rx_count;

    assign wr_data = bus_sel &&  bus_wr && (bus_addr == ADDR_DATA);
    assign rd_data = bus_sel && !bus_wr && (bus_addr == ADDR_DATA);
    assign wr_stat = bus_sel &&  bus_wr && (bus_addr == ADDR_STAT);
    assign tx_push = wr_data && !tx_full;
    assign rx_pop  = rd_data && !rx_empty;
    assign rx_push = rx_done && !rx_full;
    assign irq_rx  = en_rx && !rx_empty;
    assign irq_tx  = en_tx && !tx_full;

    dx_baud #(.DW(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
    );

    dx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata), .pop(tx_pop),
        .dout(tx_head), .empty(tx_empty), .full(tx_full), .count(tx_count)
    );

    dx_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fifo_empty(tx_empty),
        .fifo_dout(tx_head), .fifo_pop(tx_pop), .tx(serial_tx), .busy(tx_busy)
    );

    dx_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(serial_rx),
        .frame_ok(rx_done), .data(rx_byte)
    );

    dx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte), .pop(rx_pop),
        .dout(rx_head), .empty(rx_empty), .full(rx_full), .count(rx_count)
    );

    // Control registers: divider, interrupt enables and sticky error flags (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DIV_RESET);
            en_rx <= 1'b0;
            en_tx <= 1'b0;
            ovf_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (bus_sel && bus_wr && bus_addr == ADDR_DIV) div_q <= DIV_W'(bus_wdata);
            if (bus_sel && bus_wr && bus_addr == ADDR_CTRL) begin
                en_rx <= bus_wdata[0];
                en_tx <= bus_wdata[1];
            end
            if (wr_data && tx_full)        ovf_q <= 1'b1;
            else if (wr_stat)              ovf_q <= 1'b0;
            if (rx_done && rx_full)        ovr_q <= 1'b1;
            else if (wr_stat)              ovr_q <= 1'b0;
        end
    end

    // Read multiplexer: the data address shows the receive head only.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADDR_DATA: bus_rdata = rx_empty ? '0 : rx_head;
                ADDR_STAT: bus_rdata = {{(DATA_W-4){1'b0}}, ovr_q, ovf_q, !tx_full, !rx_empty};
                ADDR_DIV:  bus_rdata = DATA_W'(div_q);
                default:   bus_rdata = {{(DATA_W-2){1'b0}}, en_tx, en_rx};
            endcase
        end
    end
endmodule

// File: rtl/uart_duplex_port_chk.sv
// uart_duplex_port_chk: property checker attached to every uart_duplex_port
// instance. It only observes ports and FIFO occupancy.
module uart_duplex_port_chk #(
    parameter int CW = 5,
    parameter int DEPTH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [1:0]    bus_addr,
    input logic [7:0]    bus_rdata,
    input logic          serial_tx,
    input logic          irq_rx,
    input logic          irq_tx,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          rx_push,
    input logic          tx_busy,
    input logic          ovf_q,
    input logic          ovr_q
);
    a_r4_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

    a_r5_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd0 && tx_count == CW'(DEPTH)) |=> ovf_q);

    a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 2'd0 && rx_count == '0) |-> bus_rdata == 8'd0);

    a_r7_read_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 2'd0 && rx_count != '0 && !rx_push)
        |=> rx_count == $past(rx_count) - 1'b1);

    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> serial_tx);

    a_r8_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd1) |=> !ovf_q);

    a_r11_irq_rx: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> rx_count != '0);

    a_r11_irq_tx: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> tx_count != CW'(DEPTH));
endmodule

bind uart_duplex_port uart_duplex_port_chk #(.CW(CW), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .serial_tx(serial_tx),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .tx_count(tx_count), .rx_count(rx_count),
    .rx_push(rx_push), .tx_busy(tx_busy), .ovf_q(ovf_q), .ovr_q(ovr_q)
);

// File: tb/uart_duplex_port_test.sv
module uart_duplex_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       serial_tx, irq_rx, irq_tx;
    logic       loopback = 1'b0, rx_drv = 1'b1;
    logic       serial_rx;
    int         errors = 0, checks = 0;
    int         bitc = 64;
    bit         done = 1'b0;
    logic [7:0] got_q[$];
    int         frame_errs = 0;

    assign serial_rx = loopback ? serial_tx : rx_drv;

    always #10 clk = ~clk;

    uart_duplex_port uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .serial_tx(serial_tx), .serial_rx(serial_rx), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    function automatic logic [7:0] exp_status(bit avail, bit room, bit ovf, bit ovr);
        return {4'b0, ovr, ovf, room, avail};
    endfunction

    function automatic int bit_cycles(int div);
        return 16 * (div + 1);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic send_rx(logic [7:0] b, bit good_stop);
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (bitc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_drv = b[i];
            repeat (bitc) @(negedge clk);
        end
        rx_drv = good_stop;
        repeat (bitc) @(negedge clk);
        rx_drv = 1'b1;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // Independent decoder of the transmit line at its own mid-bit points.
    always begin
        logic [7:0] b;
        bit ok;
        @(negedge serial_tx);
        repeat (bitc / 2) @(negedge clk);
        ok = (serial_tx == 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (bitc) @(negedge clk);
            b[i] = serial_tx;
        end
        repeat (bitc) @(negedge clk);
        if (!ok || serial_tx !== 1'b1) frame_errs++;
        got_q.push_back(b);
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        logic [7:0] wb[18];
        logic [7:0] tb_q[$];
        logic [7:0] rb_q[$];
        void'($urandom(32'd20240611));
        wait_cycles(5);
        rst_n = 1'b1;
        wait_cycles(2);

        // R12: reset state
        bus_read(2'd1, r); chk("R12 status", r, exp_status(0, 1, 0, 0));
        chk("R12 tx idle", serial_tx, 1);
        chk("R12 irq", {irq_rx, irq_tx}, 0);
        bus_read(2'd3, r); chk("R12 ctrl", r, 0);
        bus_read(2'd2, r); chk("R10 divider reset", r, 3);
        bus_read(2'd0, r); chk("R7 empty read zero", r, 0);
        bus_read(2'd1, r); chk("R7 empty read no effect", r, exp_status(0, 1, 0, 0));

        // R4/R5/R6: burst of 18 writes in loopback
        loopback = 1'b1;
        for (int i = 0; i < 18; i++) begin
            wb[i] = 8'($urandom);
            bus_write(2'd0, wb[i]);
        end
        bus_read(2'd1, r); chk("R5 overflow when full", r, exp_status(0, 0, 1, 0));
        bus_read(2'd0, r); chk("R1 read never returns written", r, 0);
        wait_cycles(17 * 10 * bitc + 4 * bitc);
        chk("R4 17 frames sent", got_q.size(), 17);
        chk("R2 frame format", frame_errs, 0);
        for (int i = 0; i < 17; i++)
            if (i < got_q.size()) chk("R4 tx order", got_q[i], wb[i]);
        got_q.delete();
        bus_read(2'd1, r); chk("R6 overrun on full", r, exp_status(1, 1, 1, 1));
        for (int i = 0; i < 16; i++) begin
            bus_read(2'd0, r); chk("R1 read head in order", r, wb[i]);
        end
        bus_read(2'd0, r); chk("R7 read after drain", r, 0);
        bus_read(2'd1, r); chk("R7 drained status", r, exp_status(0, 1, 1, 1));
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, r); chk("R8 status write clears", r, exp_status(0, 1, 0, 0));

        // R3: two rounds of simultaneous random traffic
        loopback = 1'b0;
        for (int round = 0; round < 2; round++) begin
            int n;
            n = 3 + round * 5;
            tb_q.delete(); rb_q.delete();
            for (int i = 0; i < n; i++) begin
                tb_q.push_back(8'($urandom));
                rb_q.push_back(8'($urandom));
            end
            fork
                for (int i = 0; i < n; i++) bus_write(2'd0, tb_q[i]);
                for (int i = 0; i < n; i++) send_rx(rb_q[i], 1'b1);
            join
            wait_cycles(12 * bitc);
            chk("R3 tx count during rx", got_q.size(), n);
            for (int i = 0; i < n; i++)
                if (i < got_q.size()) chk("R3 tx data", got_q[i], tb_q[i]);
            got_q.delete();
            for (int i = 0; i < n; i++) begin
                bus_read(2'd0, r); chk("R3 rx data", r, rb_q[i]);
            end
            bus_read(2'd1, r); chk("R3 status after duplex", r, exp_status(0, 1, 0, 0));
        end

        // R9: short low pulse and bad stop bit
        @(negedge clk); rx_drv = 1'b0;
        wait_cycles(bitc / 4);
        rx_drv = 1'b1;
        wait_cycles(12 * bitc);
        bus_read(2'd1, r); chk("R9 glitch ignored", r, exp_status(0, 1, 0, 0));
        send_rx(8'h5A, 1'b0);
        wait_cycles(12 * bitc);
        bus_read(2'd1, r); chk("R9 bad stop discarded", r, exp_status(0, 1, 0, 0));
        send_rx(8'hC3, 1'b1);
        wait_cycles(2 * bitc);
        bus_read(2'd0, r); chk("R9 recovers after bad stop", r, 8'hC3);

        // R11: interrupts follow flags
        bus_write(2'd3, 8'h03);
        bus_read(2'd3, r); chk("R11 ctrl readback", r, 3);
        chk("R11 irq idle", {irq_rx, irq_tx}, 2'b01);
        send_rx(8'h81, 1'b1);
        wait_cycles(2 * bitc);
        chk("R11 irq rx set", {irq_rx, irq_tx}, 2'b11);
        bus_read(2'd0, r); chk("R11 data", r, 8'h81);
        chk("R11 irq rx cleared", {irq_rx, irq_tx}, 2'b01);
        bus_write(2'd3, 8'h00);
        chk("R11 irq disabled", {irq_rx, irq_tx}, 2'b00);

        // R10: faster divider, loopback
        bus_write(2'd2, 8'd1);
        bus_read(2'd2, r); chk("R10 divider write", r, 1);
        bitc = bit_cycles(1);
        loopback = 1'b1;
        bus_write(2'd0, 8'hA7);
        wait_cycles(14 * bitc);
        chk("R10 frame at new rate", got_q.size(), 1);
        if (got_q.size() > 0) chk("R2 data at new rate", got_q[0], 8'hA7);
        bus_read(2'd0, r); chk("R10 loopback receive", r, 8'hA7);
        chk("R2 no framing errors", frame_errs, 0);

        finish_run();
    end
endmodule